// File: doc/BRIEF.md
# Multi-Level Bus Interrupt Arbiter

This block sits on the processor side of a bus where devices raise interrupts on four request lines. Each line carries a fixed priority level, 4 through 7. A three-bit processor priority register decides which levels may interrupt. A line at level L qualifies only when the register holds a value below L. The arbiter drives a grant on the highest qualifying line, then waits for a vector from the device that takes the grant.

Several devices may share one request line. Inside the block, each line's grant runs through a chain of device cells. A device that is not requesting forwards the grant to the next cell. The first requesting device, the one nearest the processor, keeps the grant and supplies a six-bit vector index. The arbiter presents that index as a byte address aligned to four bytes, together with the granted level, to the instruction core and holds it until the core signals that it has taken it. The grant stays up until the serviced device drops its request. Only then does the arbiter go back to idle and arbitrate again.

The processor priority changes only through a write port. In a full system the value written would come from the status word fetched through the vector, so accepting an interrupt does not raise the level in hardware.

Top module: `pri_irq_arbiter`

## Requirements
- R1: After reset, grantOut and devAck are all zero, vecValid is 0, and curPrio is 0.
- R2: Level L (L = 4 + line index, grantOut bit 0 = level 4) is granted only when curPrio < L. Any curPrio from 0 to 3 leaves all four levels enabled.
- R3: While curPrio is 7, no grant is ever issued, whatever the requests.
- R4: When several qualifying lines request at once, exactly one grant is issued, on the highest level.
- R5: Devices are numbered d = line*2 + position, with position 0 nearest the processor. Within a granted line, devAck goes to the lowest-position requesting device, and a non-requesting device passes the grant on.
- R6: One cycle after the grant is absorbed, vecValid rises with vecAddr = {index, 2'b00}, where index is the acknowledged device's six-bit field devVecIdx[d*6 +: 6]. vecLevel shows the granted level. Both stay stable while vecValid is high, and vecValid falls on the edge where vecTaken is sampled high.
- R7: curPrio changes only when prioWe is high. Presenting or taking a vector leaves it unchanged.
- R8: After vecTaken, the grant stays on the same line until the acknowledged device drops its request. No new arbitration happens while a grant is outstanding, even if a higher level requests.
- R9: If no device on the granted line is requesting when the grant arrives, the grant is withdrawn on the next edge and no vector is presented.
- R10: A value written through prioIn with prioWe high appears on curPrio after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devReq | input | 8 | Per-device request; device d sits on line d/2 |
| devVecIdx | input | 48 | Six-bit vector index for each device, device d at bits d*6 +: 6 |
| vecTaken | input | 1 | Core has taken the presented vector |
| prioWe | input | 1 | Write strobe for the processor priority |
| prioIn | input | 3 | New processor priority value |
| grantOut | output | 4 | Line grants, bit 0 = level 4 |
| devAck | output | 8 | Device that absorbed the grant |
| vecValid | output | 1 | Vector and level are presented to the core |
| vecAddr | output | 8 | Vector byte address, low two bits zero |
| vecLevel | output | 3 | Level of the presented vector |
| curPrio | output | 3 | Current processor priority |

## Verification
The embedded properties check on every cycle that at most one line is granted, that a new grant never appears on a level the previous priority masked or below a higher active line, and that priority 7 keeps the grant lines quiet. They also check that a presented vector is aligned, stays stable and only appears while a grant is up, and that the priority holds without a write. The bench scenarios cover the rest: which device in a chain wins, that the sequence of serviced vectors follows level and chain order, that a late higher request does not take over a grant in progress, and that a withdrawn request produces no vector.

// File: rtl/pri_irq_pkg.sv
package pri_irq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_GRANT   = 2'd1,
    ST_PRESENT = 2'd2,
    ST_RELEASE = 2'd3
  } arbState_t;

  typedef struct packed {
    logic grantLoad;
    logic grantClear;
    logic vecCapture;
  } arbStrobe_t;

endpackage

// File: rtl/pri_irq_chain_cell.sv
module pri_irq_chain_cell (
  input  logic grantIn,
  input  logic reqIn,
  output logic grantPass,
  output logic ackOut
);
  // Absorb the grant when requesting, otherwise hand it downstream.
  assign ackOut    = grantIn & reqIn;
  assign grantPass = grantIn & ~reqIn;
endmodule

// File: rtl/pri_irq_ctrl.sv
module pri_irq_ctrl
  import pri_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyEligible,
  input  logic       anyAck,
  input  logic       ackReleased,
  input  logic       vecTaken,
  output arbStrobe_t strobe,
  output logic       vecValid
);

  arbState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (anyEligible) begin
          strobe.grantLoad = 1'b1;
          stateNext        = ST_GRANT;
        end
      end
      ST_GRANT: begin
        if (anyAck) begin
          strobe.vecCapture = 1'b1;
          stateNext         = ST_PRESENT;
        end else begin
          strobe.grantClear = 1'b1;
          stateNext         = ST_IDLE;
        end
      end
      ST_PRESENT: begin
        if (vecTaken) stateNext = ST_RELEASE;
      end
      ST_RELEASE: begin
        if (ackReleased) begin
          strobe.grantClear = 1'b1;
          stateNext         = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign vecValid = (state == ST_PRESENT);

  // R6: vector stays presented until the core takes it
  p_vec_held_r6: assert property (@(posedge clk) disable iff (!rstN)
    (vecValid && !vecTaken) |=> vecValid);

  // R6: vector withdrawn on the edge that samples vecTaken
  p_vec_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (vecValid && vecTaken) |=> !vecValid);

endmodule

// File: rtl/pri_irq_datapath.sv
module pri_irq_datapath
  import pri_irq_pkg::*;
#(
  parameter int NUM_LVL     = 4,
  parameter int DEV_PER_LVL = 2,
  parameter int BASE_LVL    = 4,
  parameter int PRIO_W      = 3,
  parameter int IDX_W       = 6,
  localparam int NUM_DEV    = NUM_LVL * DEV_PER_LVL,
  localparam int ALIGN_BITS = 2,
  localparam int ADDR_W     = IDX_W + ALIGN_BITS,
  localparam int DEV_IDX_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  arbStrobe_t               strobe,
  input  logic [NUM_DEV-1:0]       devReq,
  input  logic [NUM_DEV*IDX_W-1:0] devVecIdx,
  input  logic                     prioWe,
  input  logic [PRIO_W-1:0]        prioIn,
  output logic [NUM_LVL-1:0]       grantOut,
  output logic [NUM_DEV-1:0]       devAck,
  output logic [PRIO_W-1:0]        curPrio,
  output logic [ADDR_W-1:0]        vecAddr,
  output logic [PRIO_W-1:0]        vecLevel,
  output logic                     anyEligible,
  output logic                     anyAck,
  output logic                     ackReleased
);

  logic [NUM_LVL-1:0]   lineReq;
  logic [NUM_LVL-1:0]   enableMask;
  logic [NUM_LVL-1:0]   eligible;
  logic [NUM_LVL-1:0]   winner;
  logic [NUM_LVL-1:0]   grantReg;
  logic [PRIO_W-1:0]    prioReg;
  logic [IDX_W-1:0]     vecReg, vecNext;
  logic [PRIO_W-1:0]    lvlReg, lvlNext;
  logic [DEV_IDX_W-1:0] ackIdxReg, ackIdxNext;

  // Per-line request OR and priority enable
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_line
    assign lineReq[l]    = |devReq[l*DEV_PER_LVL +: DEV_PER_LVL];
    assign enableMask[l] = (prioReg < PRIO_W'(BASE_LVL + l));
  end

  assign eligible    = lineReq & enableMask;
  assign anyEligible = |eligible;

  // Highest eligible line wins: later iterations overwrite earlier ones
  always_comb begin
    winner = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (eligible[l]) winner = {{(NUM_LVL-1){1'b0}}, 1'b1} << l;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 grantReg <= '0;
    else if (strobe.grantLoad) grantReg <= winner;
    else if (strobe.grantClear) grantReg <= '0;
  end

  assign grantOut = grantReg;

  // Daisy chains, one per line; position 0 is nearest the processor
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_chain
    logic [DEV_PER_LVL:0] link;
    assign link[0] = grantReg[l];
    for (genvar k = 0; k < DEV_PER_LVL; k++) begin : g_cell
      pri_irq_chain_cell u_cell (
        .grantIn  (link[k]),
        .reqIn    (devReq[l*DEV_PER_LVL + k]),
        .grantPass(link[k+1]),
        .ackOut   (devAck[l*DEV_PER_LVL + k])
      );
    end
  end

  assign anyAck = |devAck;

  // Vector bus: the acknowledged device drives its index
  always_comb begin
    ackIdxNext = '0;
    vecNext    = '0;
    for (int d = 0; d < NUM_DEV; d++) begin
      if (devAck[d]) begin
        ackIdxNext = DEV_IDX_W'(d);
        vecNext    = devVecIdx[d*IDX_W +: IDX_W];
      end
    end
  end

  always_comb begin
    lvlNext = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (grantReg[l]) lvlNext = PRIO_W'(BASE_LVL + l);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecReg    <= '0;
      lvlReg    <= '0;
      ackIdxReg <= '0;
    end else if (strobe.vecCapture) begin
      vecReg    <= vecNext;
      lvlReg    <= lvlNext;
      ackIdxReg <= ackIdxNext;
    end
  end

  assign ackReleased = ~devReq[ackIdxReg];
  assign vecAddr     = {vecReg, {ALIGN_BITS{1'b0}}};
  assign vecLevel    = lvlReg;

  // Processor priority: only the write port moves it
  always_ff @(posedge clk) begin
    if (!rstN)       prioReg <= '0;
    else if (prioWe) prioReg <= prioIn;
  end

  assign curPrio = prioReg;

  // R4: never more than one line granted
  p_grant_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantReg));

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_chk
    // R2: a fresh grant only on a level above the priority in force
    p_grant_enabled_r2: assert property (@(posedge clk) disable iff (!rstN)
      $rose(grantReg[l]) |-> ($past(prioReg) < PRIO_W'(BASE_LVL + l)));
    // R4: no higher line was requesting when this one was granted
    p_grant_highest_r4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(grantReg[l]) |-> (($past(lineReq) >> (l + 1)) == '0));
  end

endmodule

// File: rtl/pri_irq_arbiter.sv
module pri_irq_arbiter
  import pri_irq_pkg::*;
#(
  parameter int NUM_LVL     = 4,
  parameter int DEV_PER_LVL = 2,
  parameter int BASE_LVL    = 4,
  parameter int PRIO_W      = 3,
  parameter int IDX_W       = 6,
  localparam int NUM_DEV    = NUM_LVL * DEV_PER_LVL,
  localparam int ADDR_W     = IDX_W + 2,
  localparam logic [PRIO_W-1:0] MAX_PRIO = '1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_DEV-1:0]       devReq,
  input  logic [NUM_DEV*IDX_W-1:0] devVecIdx,
  input  logic                     vecTaken,
  input  logic                     prioWe,
  input  logic [PRIO_W-1:0]        prioIn,
  output logic [NUM_LVL-1:0]       grantOut,
  output logic [NUM_DEV-1:0]       devAck,
  output logic                     vecValid,
  output logic [ADDR_W-1:0]        vecAddr,
  output logic [PRIO_W-1:0]        vecLevel,
  output logic [PRIO_W-1:0]        curPrio
);

  arbStrobe_t strobe;
  logic       anyEligible;
  logic       anyAck;
  logic       ackReleased;

  pri_irq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .anyEligible(anyEligible),
    .anyAck     (anyAck),
    .ackReleased(ackReleased),
    .vecTaken   (vecTaken),
    .strobe     (strobe),
    .vecValid   (vecValid)
  );

  pri_irq_datapath #(
    .NUM_LVL    (NUM_LVL),
    .DEV_PER_LVL(DEV_PER_LVL),
    .BASE_LVL   (BASE_LVL),
    .PRIO_W     (PRIO_W),
    .IDX_W      (IDX_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .devReq     (devReq),
    .devVecIdx  (devVecIdx),
    .prioWe     (prioWe),
    .prioIn     (prioIn),
    .grantOut   (grantOut),
    .devAck     (devAck),
    .curPrio    (curPrio),
    .vecAddr    (vecAddr),
    .vecLevel   (vecLevel),
    .anyEligible(anyEligible),
    .anyAck     (anyAck),
    .ackReleased(ackReleased)
  );

  // R3: top priority keeps every grant line quiet
  p_max_prio_blocks_r3: assert property (@(posedge clk) disable iff (!rstN)
    (curPrio == MAX_PRIO && grantOut == '0) |=> (grantOut == '0));

  // R6: presented address is longword aligned
  p_vec_aligned_r6: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (vecAddr[1:0] == 2'b00));

  // R6: address and level stay put while waiting for the core
  p_vec_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (vecValid && !vecTaken) |=> ($stable(vecAddr) && $stable(vecLevel)));

  // R8: a vector is only presented while a grant is held
  p_vec_under_grant_r8: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (grantOut != '0));

  // R7: priority holds without a write
  p_prio_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !prioWe |=> $stable(curPrio));

endmodule

// File: tb/pri_irq_arbiter_tb.sv
module pri_irq_arbiter_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] devReq;
  logic [47:0] devVecIdx;
  logic       vecTaken;
  logic       prioWe;
  logic [2:0] prioIn;
  logic [3:0] grantOut;
  logic [7:0] devAck;
  logic       vecValid;
  logic [7:0] vecAddr;
  logic [2:0] vecLevel;
  logic [2:0] curPrio;

  logic [7:0] reqSet;
  logic [7:0] clrReq;
  int         takeDelay;
  int         compared;
  int         mismatched;
  bit         finished;

  logic [7:0] expAddrQ[$];
  logic [2:0] expLvlQ[$];
  string      expTagQ[$];

  assign devReq = reqSet & ~clrReq;

  always #4 clk = ~clk;

  pri_irq_arbiter u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .devReq   (devReq),
    .devVecIdx(devVecIdx),
    .vecTaken (vecTaken),
    .prioWe   (prioWe),
    .prioIn   (prioIn),
    .grantOut (grantOut),
    .devAck   (devAck),
    .vecValid (vecValid),
    .vecAddr  (vecAddr),
    .vecLevel (vecLevel),
    .curPrio  (curPrio)
  );

  function automatic logic [5:0] vecOf(int d);
    return 6'((d * 11 + 5) % 64);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expectDev(int d, string tag);
    expAddrQ.push_back({vecOf(d), 2'b00});
    expLvlQ.push_back(3'(4 + d / 2));
    expTagQ.push_back(tag);
  endtask

  task automatic setPrio(logic [2:0] p);
    @(negedge clk);
    prioWe = 1'b1;
    prioIn = p;
    @(negedge clk);
    prioWe = 1'b0;
    check("R10 curPrio after write", 32'(curPrio), 32'(p));
  endtask

  task automatic waitDone(string tag);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 400; i++) begin
      if (expAddrQ.size() == 0 && grantOut == 4'b0 && !vecValid) break;
      @(negedge clk);
    end
    check({tag, " all expected vectors seen"}, 32'(expAddrQ.size()), 32'd0);
  endtask

  task automatic clearReqs();
    reqSet = 8'h00;
    repeat (3) @(negedge clk);
  endtask

  // Monitor: compare presented vectors against the scoreboard, then take them
  initial begin : monitor
    bit pending;
    int waited;
    pending  = 1'b0;
    waited   = 0;
    vecTaken = 1'b0;
    clrReq   = 8'h00;
    forever begin
      @(negedge clk);
      if (reqSet == 8'h00) clrReq = 8'h00;
      if (vecTaken) begin
        vecTaken = 1'b0;
        clrReq   = clrReq | devAck;   // device withdraws its request
      end else if (vecValid) begin
        if (!pending) begin
          pending = 1'b1;
          waited  = 0;
          if (expAddrQ.size() == 0) begin
            compared++;
            mismatched++;
            $display("FAIL R9 unexpected vector actual=%0h expected=none", vecAddr);
          end else begin
            check({expTagQ[0], " R6 vecAddr"}, 32'(vecAddr), 32'(expAddrQ[0]));
            check({expTagQ[0], " R6 vecLevel"}, 32'(vecLevel), 32'(expLvlQ[0]));
            void'(expAddrQ.pop_front());
            void'(expLvlQ.pop_front());
            void'(expTagQ.pop_front());
          end
        end
        if (waited >= takeDelay) begin
          vecTaken = 1'b1;
          pending  = 1'b0;
        end else begin
          waited++;
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // Driver
  initial begin
    compared   = 0;
    mismatched = 0;
    finished   = 1'b0;
    takeDelay  = 0;
    rstN       = 1'b0;
    reqSet     = 8'h00;
    prioWe     = 1'b0;
    prioIn     = 3'd0;
    for (int d = 0; d < 8; d++) devVecIdx[d*6 +: 6] = vecOf(d);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 grantOut", 32'(grantOut), 32'd0);
    check("R1 devAck", 32'(devAck), 32'd0);
    check("R1 vecValid", 32'(vecValid), 32'd0);
    check("R1 curPrio", 32'(curPrio), 32'd0);

    // R2: single level-4 request at priority 0
    expectDev(0, "R2 lvl4 prio0");
    reqSet[0] = 1'b1;
    waitDone("R2 lvl4");
    clearReqs();

    // R2: level 5 masked at priority 5, level 6 passes
    setPrio(3'd5);
    reqSet[2] = 1'b1;
    repeat (6) @(negedge clk);
    check("R2 lvl5 masked at prio5 grantOut", 32'(grantOut), 32'd0);
    check("R2 lvl5 masked vecValid", 32'(vecValid), 32'd0);
    expectDev(4, "R2 lvl6 above prio5");
    reqSet[4] = 1'b1;
    waitDone("R2 lvl6");
    check("R7 curPrio unchanged by vector", 32'(curPrio), 32'd5);
    expectDev(2, "R2 lvl5 after prio4");
    setPrio(3'd4);
    waitDone("R2 lvl5");
    check("R7 curPrio unchanged after lvl5", 32'(curPrio), 32'd4);
    clearReqs();

    // R3: priority 7 blocks everything
    setPrio(3'd7);
    reqSet = 8'hFF;
    repeat (8) @(negedge clk);
    check("R3 grantOut at prio7", 32'(grantOut), 32'd0);
    check("R3 devAck at prio7", 32'(devAck), 32'd0);
    check("R3 vecValid at prio7", 32'(vecValid), 32'd0);

    // R4/R5: all eight pending, served by level then chain position
    expectDev(6, "R4 lvl7 pos0");
    expectDev(7, "R5 lvl7 pos1");
    expectDev(4, "R4 lvl6 pos0");
    expectDev(5, "R5 lvl6 pos1");
    expectDev(2, "R4 lvl5 pos0");
    expectDev(3, "R5 lvl5 pos1");
    expectDev(0, "R4 lvl4 pos0");
    expectDev(1, "R5 lvl4 pos1");
    setPrio(3'd3);
    waitDone("R4 ordered service");
    check("R7 curPrio after eight vectors", 32'(curPrio), 32'd3);
    clearReqs();

    // R5: nearest device idle, grant passes to position 1
    setPrio(3'd0);
    expectDev(5, "R5 pass-through");
    reqSet[5] = 1'b1;
    @(negedge clk);
    check("R5 line grant", 32'(grantOut), 32'b0100);
    check("R5 devAck on pos1", 32'(devAck), 32'b0010_0000);
    waitDone("R5 pass-through");
    clearReqs();

    // R8: late higher request does not steal an outstanding grant
    takeDelay = 6;
    expectDev(0, "R8 first lvl4");
    expectDev(6, "R8 then lvl7");
    reqSet[0] = 1'b1;
    @(negedge clk);
    check("R8 initial grant lvl4", 32'(grantOut), 32'b0001);
    reqSet[6] = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 grant kept on lvl4", 32'(grantOut), 32'b0001);
    check("R8 lvl7 device not acked", 32'(devAck[6]), 32'd0);
    check("R8 presented level", 32'(vecLevel), 32'd4);
    waitDone("R8 hold");
    takeDelay = 0;
    clearReqs();

    // R9: request withdrawn before the grant reaches any device
    @(negedge clk);
    reqSet[0] = 1'b1;
    @(negedge clk);
    check("R9 grant issued", 32'(grantOut), 32'b0001);
    reqSet[0] = 1'b0;
    @(negedge clk);
    check("R9 grant withdrawn", 32'(grantOut), 32'd0);
    check("R9 no vector", 32'(vecValid), 32'd0);
    repeat (5) @(negedge clk);
    check("R9 still idle", 32'(grantOut), 32'd0);
    clearReqs();

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule